// File: doc/BRIEF.md
# Interrupt Enable and Entry Controller

This block is the interrupt front end of a 12-bit accumulator processor whose opcodes are written in octal. It watches the instruction register each time the processor reports that an instruction has finished. From that instruction it recognises the pair of I/O instructions that turn interrupts on and off, and it keeps the single interrupt-enable flip-flop that those instructions control.

Between instructions it samples the device request line. When it accepts a request, it raises a one-cycle take strobe and latches the return address, which is the processor's PC at the moment the instruction completed. It also clears the enable. During that entry cycle it blocks the processor's PC increment request, so the saved address is exactly the next instruction to run and not one past it. The processor then writes the return address to location 0000 and continues at 0001.

All pins are plain control and status lines. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure. An active-low global clear puts every flip-flop in a known state.

Top module: `irq_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, `ie_o` = 0, `take_o` = 0 and `ret_addr_o` = 0.
- R2: An instruction is an interrupt-control instruction when `ir_i[11:9]` = 3'b110 and `ir_i[8:3]` = 0. For such an instruction, `ir_i[0]` = 1 means enable-on and `ir_i[0]` = 0 means enable-off; bits 2:1 are not decoded. The code octal 6001 is therefore on and 6002 is off. On the clock edge where `done_i` is high, enable-on sets `ie_o` and enable-off clears it. Every other instruction code leaves `ie_o` unchanged.
- R3: While `done_i` is low, `ir_i` has no effect on `ie_o`.
- R4: An interrupt is taken when `done_i` is high, `ie_o` is 1, `irq_i` is 1 and the completing instruction is not an interrupt-control instruction. On the next cycle `take_o` is high for exactly one cycle.
- R5: The completion of an enable-on instruction never takes an interrupt, even if `ie_o` was already 1. The earliest take is at the completion of the following instruction.
- R6: The completion of an enable-off instruction never takes an interrupt.
- R7: `irq_i` is sampled only when `done_i` is high. A request that is present only while `done_i` is low causes no take.
- R8: In the cycle `take_o` is high, `ret_addr_o` equals the `pc_i` value present at the accepting completion. The value holds until the next take.
- R9: Taking an interrupt clears `ie_o` on the same edge that raises `take_o`.
- R10: `pc_inc_o` follows `inc_req_i`, except that it is forced to 0 in the cycle `take_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low global clear |
| ir_i | input | 12 | Instruction register of the completing instruction |
| done_i | input | 1 | Instruction-complete strobe (end of execute) |
| irq_i | input | 1 | Device interrupt request |
| pc_i | input | 12 | Address of the next instruction |
| inc_req_i | input | 1 | Processor's PC increment request |
| ie_o | output | 1 | Interrupt-enable state |
| take_o | output | 1 | One-cycle interrupt-entry strobe |
| ret_addr_o | output | 12 | Return address to save at location 0000 |
| pc_inc_o | output | 1 | Gated PC increment |

## Verification
A wrong enable state shows on `ie_o` one edge after the completion that caused it. It also shows as a missing or extra `take_o` pulse at the next completion that carries a request. A wrong decode of any of the 4096 instruction codes would leave `ie_o` at the wrong value right after that instruction completes, so the bench sweeps every code starting from both enable states. An error in entry capture shows in the take cycle itself, either as a `ret_addr_o` off by one from `pc_i` or as a `pc_inc_o` pulse during entry.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int WORD_W = 12;
  localparam int OPC_W  = 3;
  localparam int DEV_W  = 6;
  localparam logic [OPC_W-1:0] IOT_OPC = 3'o6;

  typedef struct packed {
    logic turn_on;
    logic turn_off;
  } iec_dec_t;
endpackage

// File: rtl/irq_iot_decode.sv
module irq_iot_decode
  import irq_ctrl_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] ir,
  output iec_dec_t     dec
);
  localparam int OPC_LSB = W - OPC_W;
  localparam int DEV_LSB = OPC_LSB - DEV_W;

  logic grp;
  // interrupt-control group: IOT opcode with device field of zero (R2)
  assign grp = (ir[W-1:OPC_LSB] == IOT_OPC) && (ir[OPC_LSB-1:DEV_LSB] == '0);

  always_comb begin
    dec.turn_on  = grp &  ir[0];
    dec.turn_off = grp & ~ir[0];
  end

  always_comb begin
    assert (!(dec.turn_on && dec.turn_off)) else $error("p_dec_exclusive_r2");
  end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import irq_ctrl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     done,
  input  iec_dec_t dec,
  input  logic     take_now,
  output logic     ie
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ie <= 1'b0;
    else if (take_now)             ie <= 1'b0;
    else if (done && dec.turn_on)  ie <= 1'b1;
    else if (done && dec.turn_off) ie <= 1'b0;
  end

  p_on_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dec.turn_on) |=> ie);
  p_off_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dec.turn_off) |=> !ie);
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!done) |=> $stable(ie));
endmodule

// File: rtl/irq_entry.sv
module irq_entry
  import irq_ctrl_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         done,
  input  logic         ie,
  input  logic         irq,
  input  iec_dec_t     dec,
  input  logic [W-1:0] pc,
  output logic         take_now,
  output logic         take_q,
  output logic [W-1:0] ret_q
);
  // request sampled only at completion; control instructions shield their own end
  assign take_now = done & ie & irq & ~dec.turn_on & ~dec.turn_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      ret_q  <= '0;
    end else begin
      take_q <= take_now;
      if (take_now) ret_q <= pc;
    end
  end

  p_take_needs_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> $past(done && irq));
  p_take_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |=> !take_q);
  p_ret_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !take_q |-> $stable(ret_q));
  p_take_ret_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> (ret_q == $past(pc)));
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ir_i,
  input  logic         done_i,
  input  logic         irq_i,
  input  logic [W-1:0] pc_i,
  input  logic         inc_req_i,
  output logic         ie_o,
  output logic         take_o,
  output logic [W-1:0] ret_addr_o,
  output logic         pc_inc_o
);
  iec_dec_t dec;
  logic     take_now;

  irq_iot_decode #(.W(W)) u_dec (.ir(ir_i), .dec(dec));

  irq_enable_reg u_ie (
    .clk(clk), .rst_n(rst_n), .done(done_i), .dec(dec),
    .take_now(take_now), .ie(ie_o)
  );

  irq_entry #(.W(W)) u_ent (
    .clk(clk), .rst_n(rst_n), .done(done_i), .ie(ie_o), .irq(irq_i),
    .dec(dec), .pc(pc_i), .take_now(take_now), .take_q(take_o),
    .ret_q(ret_addr_o)
  );

  // entry cycle must not advance the PC, else the saved address is one high
  assign pc_inc_o = inc_req_i & ~take_o;

  p_no_inc_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !pc_inc_o);
  p_take_clears_ie_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> !ie_o);
  p_on_no_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && dec.turn_on) |=> !take_o);
  p_off_no_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && dec.turn_off) |=> !take_o);
endmodule

// File: tb/irq_ctrl_test.sv
module irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] ION = 12'o6001;
  localparam logic [11:0] IOF = 12'o6002;
  localparam logic [11:0] NOP = 12'o7000;

  logic clk = 0;
  logic rst_n = 0;
  logic [11:0] ir_i = 0, pc_i = 0;
  logic done_i = 0, irq_i = 0, inc_req_i = 0;
  logic ie_o, take_o, pc_inc_o;
  logic [11:0] ret_addr_o;

  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ir_i(ir_i), .done_i(done_i), .irq_i(irq_i),
    .pc_i(pc_i), .inc_req_i(inc_req_i), .ie_o(ie_o), .take_o(take_o),
    .ret_addr_o(ret_addr_o), .pc_inc_o(pc_inc_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic d, input logic [11:0] ir, input logic rq,
                     input logic [11:0] pc, input logic inc);
    @(negedge clk);
    done_i = d; ir_i = ir; irq_i = rq; pc_i = pc; inc_req_i = inc;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ie in reset", ie_o, 0);
    chk("R1 take in reset", take_o, 0);
    @(negedge clk); rst_n = 1;
    cyc(0, NOP, 0, 0, 0);
    chk("R1 ie after reset", ie_o, 0);
    chk("R1 ret after reset", ret_addr_o, 0);

    // R2 sweep of every instruction code from both enable states
    for (int v = 0; v < 4096; v++) begin
      bit grp, on, off;
      grp = ((v >> 9) == 6) && (((v >> 3) & 63) == 0);
      on  = grp && (v & 1);
      off = grp && !(v & 1);
      cyc(1, ION, 0, 0, 0);
      cyc(1, 12'(v), 0, 0, 0);
      chk($sformatf("R2 code %0o from on", v), ie_o, off ? 0 : 1);
      cyc(1, IOF, 0, 0, 0);
      cyc(1, 12'(v), 0, 0, 0);
      chk($sformatf("R2 code %0o from off", v), ie_o, on ? 1 : 0);
    end

    // R3: no completion, control codes ignored
    cyc(1, ION, 0, 0, 0);
    cyc(0, IOF, 0, 0, 0);
    chk("R3 off without done", ie_o, 1);
    cyc(1, IOF, 0, 0, 0);
    cyc(0, ION, 0, 0, 0);
    chk("R3 on without done", ie_o, 0);

    // R5: ION completion with request pending never takes
    cyc(1, ION, 1, 12'o0100, 0);
    chk("R5 no take at on", take_o, 0);
    chk("R5 ie set", ie_o, 1);
    cyc(1, ION, 1, 12'o0101, 0);
    chk("R5 no take at on while enabled", take_o, 0);

    // R7: request without completion ignored
    cyc(0, NOP, 1, 12'o0102, 1);
    chk("R7 no take without done", take_o, 0);
    cyc(0, NOP, 1, 12'o0102, 1);
    chk("R7 no take without done 2", take_o, 0);
    chk("R10 inc passes", pc_inc_o, 1);

    // R4/R8/R9/R10: take at page boundary address
    cyc(1, NOP, 1, 12'o0200, 1);
    chk("R4 take pulse", take_o, 1);
    chk("R8 ret addr", ret_addr_o, 12'o0200);
    chk("R9 ie cleared", ie_o, 0);
    chk("R10 inc blocked", pc_inc_o, 0);
    cyc(0, NOP, 1, 12'o0001, 1);
    chk("R4 single pulse", take_o, 0);
    chk("R10 inc resumes", pc_inc_o, 1);
    chk("R8 ret held", ret_addr_o, 12'o0200);
    cyc(1, NOP, 1, 12'o0002, 0);
    chk("R4 no take while disabled", take_o, 0);
    chk("R8 ret held disabled", ret_addr_o, 12'o0200);

    // R6: IOF completion with pending request
    cyc(1, ION, 0, 0, 0);
    cyc(1, IOF, 1, 12'o0300, 0);
    chk("R6 no take at off", take_o, 0);
    chk("R6 ie cleared", ie_o, 0);

    // R4 sweep of return addresses
    for (int k = 0; k < 64; k++) begin
      logic [11:0] a;
      a = 12'((k * 12'o0163 + 7) & 12'o7777);
      cyc(1, ION, 0, 0, 0);
      cyc(1, NOP, 1, a, 1);
      chk("R4 take in sweep", take_o, 1);
      chk("R8 ret sweep", ret_addr_o, a);
      chk("R10 inc blocked sweep", pc_inc_o, 0);
      cyc(0, NOP, 0, 0, 0);
    end

    // R1: reset mid-run
    cyc(1, ION, 0, 0, 0);
    @(negedge clk); rst_n = 0;
    #1;
    chk("R1 ie async clear", ie_o, 0);
    chk("R1 ret async clear", ret_addr_o, 0);
    @(negedge clk); rst_n = 1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule